// File: doc/BRIEF.md
# Fixed-Priority Interrupt Arbiter

This block decides which pending interrupt a small 8-bit controller core services next. Peripheral request lines feed a bank of pending latches. Each latched request is then qualified by a per-source enable mask and by the core's global interrupt-enable flag, and a fixed-priority encoder picks the winner. When a source wins, the arbiter raises a one-cycle take strobe together with the 4-bit number of that source. It then waits for the core to acknowledge before it offers another interrupt.

There are thirteen sources. The three at the top of the order (software trap, non-maskable, watchdog) are always unmasked. The ten below them are each qualified by their own mask bit, and every source is gated by the global flag. An acknowledge clears the pending latch of the source that was taken if that source is sticky. A level source simply follows its request line. The enumeration carries a terminal count entry (value 13) that never appears as a source number.

Top module: `irq_arbiter`

## Requirements
- R1: While reset is asserted and after its release, take_o is 0, take_id_o is 0 and pend_o is all zeros until a request arrives.
- R2: If gie_i was low at the clock edge that makes a decision, take_o stays low whatever is pending.
- R3: Source numbers rank highest first as 0 software trap, 1 non-maskable, 2 watchdog, 3 external line 0, 4 to 8 timers 0 to 4, 9 external line 1, 10 external line 2, 11 serial receive, 12 serial transmit. A take reports the lowest-numbered qualified pending source, and exactly one source is taken per decision.
- R4: Sources 0, 1 and 2 are taken whether or not their mask_i bit is set.
- R5: Sources 3 to 12 are taken only if their mask_i bit (bit position equals source number) is 1. A masked source stays pending and is taken once its bit is set.
- R6: take_o is high for exactly one cycle. After a take, no further take occurs until ack_i has been sampled high. An ack_i sampled high ends the wait, and the next take can come one cycle later at the earliest.
- R7: An acknowledge clears the pending latch of the taken source when that source is sticky (by default every source except 2). The watchdog source 2 is level-type: its pend_o bit equals req_i[2] from the previous edge, and ack_i has no effect on it.
- R8: When req_i of the taken sticky source is high at the same edge as its acknowledge, the request wins and the pending bit remains 1.
- R9: ack_i sampled while no take is outstanding changes no pending bit and causes no take.
- R10: take_id_o never shows the terminal count value 13 or any value above it.
- R11: A request high at edge k shows on pend_o after edge k. The decision at edge k+1 uses that pending state and the mask_i and gie_i values sampled at edge k+1, so take_o rises after edge k+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 13 | Request line of each source, bit index equals source number |
| mask_i | input | 13 | Per-source enable, bits 0 to 2 are ignored |
| gie_i | input | 1 | Global interrupt enable of the core |
| ack_i | input | 1 | Core acknowledges the outstanding take |
| take_o | output | 1 | One-cycle strobe: an interrupt is taken |
| take_id_o | output | 4 | Number of the last taken source, held between takes |
| pend_o | output | 13 | Pending latches |

## Verification
The assertions assume that every input is driven to a known value from reset onward. They also assume that ack_i relates only to the most recent take: the core does not queue acknowledges. The bench changes inputs only just after a clock edge and keeps each input at 0 or 1, never X. In the directed sequences and in the random phase, it raises ack_i only while a take is outstanding, except in the deliberate idle-acknowledge case of R9.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    typedef enum logic [3:0] {
        SRC_SWTRAP = 4'd0,
        SRC_NMI    = 4'd1,
        SRC_WDOG   = 4'd2,
        SRC_EXT0   = 4'd3,
        SRC_TMR0   = 4'd4,
        SRC_TMR1   = 4'd5,
        SRC_TMR2   = 4'd6,
        SRC_TMR3   = 4'd7,
        SRC_TMR4   = 4'd8,
        SRC_EXT1   = 4'd9,
        SRC_EXT2   = 4'd10,
        SRC_SRX    = 4'd11,
        SRC_STX    = 4'd12,
        SRC_COUNT  = 4'd13
    } irq_src_e;

    localparam int NUM_SOURCES = int'(SRC_COUNT);
    localparam int NUM_UNMASKED = int'(SRC_EXT0);

endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
    parameter int N_SRC = 13,
    parameter logic [N_SRC-1:0] STICKY = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] req_i,
    input  logic [N_SRC-1:0] clr_i,
    output logic [N_SRC-1:0] pend_o
);

    logic [N_SRC-1:0] pend_d, pend_q;

    always_comb begin
        // a request always sets; sticky bits hold until cleared, level bits follow
        pend_d = req_i | (STICKY & pend_q & ~clr_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign pend_o = pend_q;

    for (genvar g = 0; g < N_SRC; g++) begin : g_chk
        if (STICKY[g]) begin : g_sticky
            p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_i[g] && !req_i[g]) |=> !pend_q[g]);
            p_req_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
                req_i[g] |=> pend_q[g]);
        end else begin : g_level
            p_level_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> (pend_q[g] == $past(req_i[g])));
        end
    end

endmodule

// File: rtl/irq_qualify.sv
module irq_qualify #(
    parameter int N_SRC = 13,
    parameter int N_UNMASKED = 3
) (
    input  logic [N_SRC-1:0] pend_i,
    input  logic [N_SRC-1:0] mask_i,
    input  logic             gie_i,
    output logic [N_SRC-1:0] qual_o
);

    localparam logic [N_SRC-1:0] FORCE_ON = N_SRC'((1 << N_UNMASKED) - 1);

    always_comb begin
        qual_o = pend_i & (mask_i | FORCE_ON) & {N_SRC{gie_i}};
    end

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int N_SRC = 13,
    parameter int ID_W  = 4
) (
    input  logic [N_SRC-1:0] qual_i,
    output logic             any_o,
    output logic [ID_W-1:0]  id_o
);

    always_comb begin
        any_o = |qual_i;
        id_o  = '0;
        // scan from the lowest rank upward so the highest rank is written last
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (qual_i[i]) id_o = ID_W'(i);
        end
    end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_arb_pkg::*;
#(
    parameter int N_SRC = NUM_SOURCES,
    parameter int N_UNMASKED = NUM_UNMASKED,
    parameter logic [N_SRC-1:0] STICKY = ~(N_SRC'(1) << int'(SRC_WDOG))
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] req_i,
    input  logic [N_SRC-1:0] mask_i,
    input  logic             gie_i,
    input  logic             ack_i,
    output logic             take_o,
    output logic [3:0]       take_id_o,
    output logic [N_SRC-1:0] pend_o
);

    localparam int ID_W = $clog2(N_SRC + 1);

    typedef struct packed {
        logic            take;
        logic            busy;
        logic [ID_W-1:0] id;
    } arb_st_t;

    arb_st_t st_d, st_q;
    logic [N_SRC-1:0] pend, qual, clr;
    logic             win_any;
    logic [ID_W-1:0]  win_id;

    irq_pend_bank #(.N_SRC(N_SRC), .STICKY(STICKY)) u_pend (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .clr_i(clr), .pend_o(pend)
    );

    irq_qualify #(.N_SRC(N_SRC), .N_UNMASKED(N_UNMASKED)) u_qual (
        .pend_i(pend), .mask_i(mask_i), .gie_i(gie_i), .qual_o(qual)
    );

    irq_prio_enc #(.N_SRC(N_SRC), .ID_W(ID_W)) u_enc (
        .qual_i(qual), .any_o(win_any), .id_o(win_id)
    );

    always_comb begin
        clr = (st_q.busy && ack_i) ? (N_SRC'(1) << st_q.id) : '0;
    end

    always_comb begin
        st_d      = st_q;
        st_d.take = !st_q.busy && win_any;
        if (st_d.take) st_d.id = win_id;
        st_d.busy = st_q.busy ? !ack_i : st_d.take;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign take_o    = st_q.take;
    assign take_id_o = 4'(st_q.id);
    assign pend_o    = pend;

    p_gated_by_gie_r2: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> $past(gie_i));

    p_highest_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (($past(qual) & ((N_SRC'(1) << take_id_o) - N_SRC'(1))) == '0));

    p_mask_respected_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && (int'(take_id_o) >= N_UNMASKED)) |-> ((($past(mask_i) >> take_id_o) & N_SRC'(1)) != '0));

    p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !take_o);

    p_wait_for_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !ack_i) |=> !take_o);

    p_no_terminal_r10: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (int'(take_id_o) < N_SRC));

endmodule

// File: tb/tb_irq_arbiter.sv
`timescale 1ns/1ps
module tb_irq_arbiter;

    localparam int N = 13;
    localparam int LEVEL_SRC = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req = '0;
    logic [N-1:0] mask = '0;
    logic         gie = 1'b0;
    logic         ack = 1'b0;
    logic         take_o;
    logic [3:0]   take_id_o;
    logic [N-1:0] pend_o;

    int checks = 0;
    int fails = 0;

    // reference state
    bit [N-1:0] m_pend = '0;
    bit         m_take = 0;
    bit         m_busy = 0;
    int         m_id = 0;

    always #2 clk = ~clk;

    irq_arbiter dut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .mask_i(mask), .gie_i(gie),
        .ack_i(ack), .take_o(take_o), .take_id_o(take_id_o), .pend_o(pend_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // advance one clock, update the model, compare all outputs
    task automatic step(input string tag);
        bit [N-1:0] n_pend;
        bit n_take, n_busy;
        int n_id, win;
        win = -1;
        for (int i = 0; i < N; i++) begin
            if (win < 0 && m_pend[i] && gie && (i < 3 || mask[i])) win = i;
        end
        n_take = !m_busy && (win >= 0);
        n_id   = n_take ? win : m_id;
        n_busy = m_busy ? !ack : n_take;
        for (int i = 0; i < N; i++) begin
            if (i == LEVEL_SRC)         n_pend[i] = req[i];
            else if (req[i])            n_pend[i] = 1;
            else if (m_busy && ack && m_id == i) n_pend[i] = 0;
            else                        n_pend[i] = m_pend[i];
        end
        @(posedge clk);
        #1;
        m_pend = n_pend; m_take = n_take; m_busy = n_busy; m_id = n_id;
        chk(take_o === m_take, {tag, " take"}, int'(take_o), int'(m_take));
        chk(take_id_o === 4'(m_id), {tag, " id"}, int'(take_id_o), m_id);
        chk(pend_o === m_pend, {tag, " pend"}, int'(pend_o), int'(m_pend));
        chk(!(take_o && take_id_o >= 4'd13), "R10 terminal", int'(take_id_o), 12);
    endtask

    task automatic drain(input string tag, input int n);
        for (int k = 0; k < n; k++) begin
            ack = m_busy;
            step(tag);
            ack = 0;
        end
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int order [$];
        int exp_next;
        repeat (3) @(posedge clk);
        #1;
        chk(take_o === 0 && pend_o === '0 && take_id_o === 0, "R1 reset", int'(take_o), 0);
        rst_n = 1;
        step("R1");
        chk(take_o === 0 && pend_o === '0, "R1 after release", int'(pend_o), 0);

        // R2: global flag low blocks everything
        mask = '1; req = '1; gie = 0;
        step("R2"); req = '0;
        for (int k = 0; k < 5; k++) begin
            step("R2");
            chk(take_o === 0, "R2 no take", int'(take_o), 0);
        end

        // R3: drain in priority order (level source 2 already dropped)
        gie = 1;
        for (int k = 0; k < 40; k++) begin
            ack = m_busy;
            step("R3");
            ack = 0;
            if (take_o) order.push_back(int'(take_id_o));
        end
        exp_next = 0;
        foreach (order[j]) begin
            if (exp_next == LEVEL_SRC) exp_next++;
            chk(order[j] == exp_next, "R3 order", order[j], exp_next);
            exp_next++;
        end
        chk(order.size() == N - 1, "R3 count", order.size(), N - 1);

        // R4 and R5: mask cleared
        mask = '0;
        req[0] = 1; req[5] = 1; req[11] = 1;
        step("R4"); req = '0;
        drain("R4", 8);
        chk(pend_o[5] === 1 && pend_o[11] === 1, "R5 masked stays pending", int'(pend_o), 'h820);
        chk(pend_o[0] === 0, "R4 unmasked taken", int'(pend_o[0]), 0);
        mask[11] = 1;
        drain("R5", 6);
        chk(pend_o[11] === 0 && pend_o[5] === 1, "R5 enabled taken", int'(pend_o), 'h20);
        mask = '1;
        drain("R5", 6);

        // R7: level watchdog source
        req[LEVEL_SRC] = 1;
        step("R7"); step("R7");
        chk(take_o === 1 && take_id_o === 4'(LEVEL_SRC), "R7 level taken", int'(take_id_o), LEVEL_SRC);
        ack = 1; step("R7"); ack = 0;
        chk(pend_o[LEVEL_SRC] === 1, "R7 level ignores ack", int'(pend_o[LEVEL_SRC]), 1);
        req[LEVEL_SRC] = 0;
        step("R7");
        chk(pend_o[LEVEL_SRC] === 0, "R7 level follows", int'(pend_o[LEVEL_SRC]), 0);
        drain("R7", 6);

        // R8 and R11: request coinciding with acknowledge; latency
        req[4] = 1;
        step("R11"); req = '0;
        chk(pend_o[4] === 1 && take_o === 0, "R11 pending first", int'(take_o), 0);
        step("R11");
        chk(take_o === 1 && take_id_o === 4'd4, "R11 take next", int'(take_id_o), 4);
        ack = 1; req[4] = 1;
        step("R8"); ack = 0; req = '0;
        chk(pend_o[4] === 1, "R8 request wins", int'(pend_o[4]), 1);
        step("R8");
        chk(take_o === 1 && take_id_o === 4'd4, "R8 retaken", int'(take_id_o), 4);
        ack = 1; step("R7"); ack = 0;
        chk(pend_o[4] === 0, "R7 sticky cleared", int'(pend_o[4]), 0);

        // R9: acknowledge while idle
        mask = '0; req[6] = 1;
        step("R9"); req = '0;
        ack = 1; step("R9"); step("R9"); ack = 0;
        chk(pend_o[6] === 1 && take_o === 0, "R9 idle ack", int'(pend_o[6]), 1);
        mask = '1;
        drain("R9", 5);

        // random phase
        for (int k = 0; k < 3000; k++) begin
            for (int i = 0; i < N; i++) req[i] = ($urandom_range(0, 15) == 0);
            mask = N'($urandom);
            gie  = ($urandom_range(0, 4) != 0);
            ack  = m_busy && ($urandom_range(0, 2) == 0);
            step("R10");
        end
        req = '0; ack = 0;

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule